// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the combinational arithmetic and logic unit of a multicycle core. Each cycle it takes two operands, a three-bit function code and a carry-in, and returns a result of the same width. It also returns four status flags that the sequencer and the branch logic use to steer control flow.

Add and subtract share one adder. Subtraction inverts the second operand and forces the adder's carry-in to one, so a carry-out means no borrow took place. The two comparison functions reuse the same subtraction and return a full-width word holding 0 or 1. The signed comparison corrects the sign of the difference with the overflow bit, so its answer stays right when the subtraction overflows.

A control decoder turns the function code into a small set of strobes. These strobes select the adder input inversion, the carry source, the result source and whether the flags are arithmetic.

Top module: `alu_core`

## Requirements
- R1: Function code 0 (add) returns {flagCarry, result} = opA + opB + carryIn, computed on WIDTH+1 bits.
- R2: Function code 1 (subtract) returns result = opA − opB modulo 2^WIDTH. flagCarry is 1 exactly when opA ≥ opB as unsigned values. carryIn has no effect on any output.
- R3: For add and subtract, flagOvf is 1 exactly when the two effective adder operands have the same sign bit and the result sign bit differs from it. For subtract, the second effective operand is ~opB.
- R4: Function codes 2, 3, 4 and 5 return opA AND opB, opA OR opB, opA XOR opB and NOT(opA OR opB) respectively. For these codes flagCarry and flagOvf are 0 and carryIn has no effect.
- R5: Function code 6 returns 1 when opA < opB as two's-complement signed values and 0 otherwise, with bits WIDTH-1..1 zero. The answer is correct even when opA − opB overflows.
- R6: Function code 7 returns 1 when opA < opB as unsigned values and 0 otherwise, with bits WIDTH-1..1 zero.
- R7: flagZero is 1 exactly when every bit of result is 0, for every function code.
- R8: flagNeg equals result bit WIDTH-1 for every function code.
- R9: For function codes 6 and 7, flagCarry and flagOvf are 0 and carryIn has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH (32) | First operand |
| opB | input | WIDTH (32) | Second operand |
| funcCode | input | 3 | Function select, encoding per R1–R6 |
| carryIn | input | 1 | Carry into the adder for add only |
| result | output | WIDTH (32) | Selected result word |
| flagZero | output | 1 | Result is all zeros |
| flagNeg | output | 1 | Most significant result bit |
| flagCarry | output | 1 | Adder carry-out for add and subtract |
| flagOvf | output | 1 | Signed overflow for add and subtract |

## Verification
Several behaviours can land on the same cycle. The main case is a signed compare whose internal subtraction overflows. The bench applies it with a most-negative first operand against a positive second one, and with a large positive operand against a negative one. It then checks that the compare still gives the true signed order and that both flags stay 0. A second case is a carry-out and a zero result together. An add of all ones plus one, and a subtract of equal values, must raise flagCarry and flagZero at once. Every applied vector is judged against a reference model in the bench that works on wider integers, independent of the adder structure.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_NOR  = 3'd5,
    FN_SLT  = 3'd6,
    FN_SLTU = 3'd7
  } aluFunc_e;

  typedef enum logic [1:0] {
    SRC_SUM   = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_CMP   = 2'd2
  } resultSrc_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logicOp_e;

  // strobes from decoder to datapath
  typedef struct packed {
    logic       invertB;     // feed ~opB into the adder
    logic       forceCarry;  // adder carry-in tied to 1
    logic       passCarry;   // adder carry-in taken from the port
    resultSrc_e resultSrc;
    logicOp_e   logicOp;
    logic       cmpUnsigned; // compare on carry rather than sign
    logic       arithFlags;  // carry/overflow flags are meaningful
  } aluStrobes_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH        = 32,
  parameter int RIPPLE_STYLE = 0
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             addCin,
  output logic [WIDTH-1:0] addSum,
  output logic             addCout
);

  generate
    if (RIPPLE_STYLE != 0) begin : g_ripple
      logic [WIDTH:0] carryChain;
      assign carryChain[0] = addCin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic halfSum;
        assign halfSum           = addA[i] ^ addB[i];
        assign addSum[i]         = halfSum ^ carryChain[i];
        assign carryChain[i + 1] = (addA[i] & addB[i]) | (halfSum & carryChain[i]);
      end
      assign addCout = carryChain[WIDTH];
    end else begin : g_infer
      logic [WIDTH:0] wideSum;
      assign wideSum = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, addCin};
      assign addSum  = wideSum[WIDTH-1:0];
      assign addCout = wideSum[WIDTH];
    end
  endgenerate

endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [2:0]  funcCode,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes             = '0;
    strobes.resultSrc   = SRC_SUM;
    strobes.logicOp     = LG_AND;
    case (aluFunc_e'(funcCode))
      FN_ADD: begin
        strobes.passCarry  = 1'b1;
        strobes.arithFlags = 1'b1;
      end
      FN_SUB: begin
        strobes.invertB    = 1'b1;
        strobes.forceCarry = 1'b1;
        strobes.arithFlags = 1'b1;
      end
      FN_AND: begin
        strobes.resultSrc = SRC_LOGIC;
        strobes.logicOp   = LG_AND;
      end
      FN_OR: begin
        strobes.resultSrc = SRC_LOGIC;
        strobes.logicOp   = LG_OR;
      end
      FN_XOR: begin
        strobes.resultSrc = SRC_LOGIC;
        strobes.logicOp   = LG_XOR;
      end
      FN_NOR: begin
        strobes.resultSrc = SRC_LOGIC;
        strobes.logicOp   = LG_NOR;
      end
      FN_SLT: begin
        strobes.invertB    = 1'b1;
        strobes.forceCarry = 1'b1;
        strobes.resultSrc  = SRC_CMP;
      end
      FN_SLTU: begin
        strobes.invertB     = 1'b1;
        strobes.forceCarry  = 1'b1;
        strobes.resultSrc   = SRC_CMP;
        strobes.cmpUnsigned = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int RIPPLE_STYLE = 0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             flagZero,
  output logic             flagNeg,
  output logic             flagCarry,
  output logic             flagOvf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] effB;
  logic             effCin;
  logic [WIDTH-1:0] sumWord;
  logic             sumCout;
  logic             sumOvf;
  logic             lessThan;
  logic [WIDTH-1:0] logicWord;

  assign effB   = strobes.invertB ? ~opB : opB;
  assign effCin = strobes.forceCarry | (strobes.passCarry & carryIn);

  alu_adder #(
    .WIDTH       (WIDTH),
    .RIPPLE_STYLE(RIPPLE_STYLE)
  ) u_adder (
    .addA   (opA),
    .addB   (effB),
    .addCin (effCin),
    .addSum (sumWord),
    .addCout(sumCout)
  );

  // same-sign operands producing opposite-sign sum
  assign sumOvf = (opA[MSB] == effB[MSB]) && (sumWord[MSB] != opA[MSB]);

  // signed: corrected sign of difference; unsigned: borrow
  assign lessThan = strobes.cmpUnsigned ? ~sumCout : (sumWord[MSB] ^ sumOvf);

  always_comb begin
    case (strobes.logicOp)
      LG_AND:  logicWord = opA & opB;
      LG_OR:   logicWord = opA | opB;
      LG_XOR:  logicWord = opA ^ opB;
      default: logicWord = ~(opA | opB);
    endcase
  end

  always_comb begin
    case (strobes.resultSrc)
      SRC_LOGIC: result = logicWord;
      SRC_CMP:   result = {{(WIDTH-1){1'b0}}, lessThan};
      default:   result = sumWord;
    endcase
  end

  assign flagZero  = ~|result;
  assign flagNeg   = result[MSB];
  assign flagCarry = strobes.arithFlags & sumCout;
  assign flagOvf   = strobes.arithFlags & sumOvf;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int RIPPLE_STYLE = 0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       funcCode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             flagZero,
  output logic             flagNeg,
  output logic             flagCarry,
  output logic             flagOvf
);

  aluStrobes_t strobes;

  alu_control u_control (
    .funcCode(funcCode),
    .strobes (strobes)
  );

  alu_datapath #(
    .WIDTH       (WIDTH),
    .RIPPLE_STYLE(RIPPLE_STYLE)
  ) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .result   (result),
    .flagZero (flagZero),
    .flagNeg  (flagNeg),
    .flagCarry(flagCarry),
    .flagOvf  (flagOvf)
  );

endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       funcCode,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             flagZero,
  input logic             flagNeg,
  input logic             flagCarry,
  input logic             flagOvf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] addRef;
  assign addRef = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (funcCode == 3'd0) begin
      assert_add_sum_R1: assert ({flagCarry, result} == addRef)
        else $error("add sum/carry mismatch");
    end
    if (funcCode == 3'd1) begin
      assert_sub_borrow_R2: assert (result == opA - opB && flagCarry == (opA >= opB))
        else $error("subtract mismatch");
      assert_sub_ovf_R3: assert (flagOvf == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB])))
        else $error("subtract overflow mismatch");
    end
    if (funcCode >= 3'd2 && funcCode <= 3'd5) begin
      assert_logic_no_flags_R4: assert (!flagCarry && !flagOvf)
        else $error("logic op raised arithmetic flag");
    end
    if (funcCode == 3'd6) begin
      assert_slt_order_R5: assert (result == {{MSB{1'b0}}, ($signed(opA) < $signed(opB))})
        else $error("signed compare mismatch");
    end
    if (funcCode == 3'd7) begin
      assert_sltu_order_R6: assert (result == {{MSB{1'b0}}, (opA < opB)})
        else $error("unsigned compare mismatch");
    end
    if (funcCode >= 3'd6) begin
      assert_cmp_no_flags_R9: assert (!flagCarry && !flagOvf)
        else $error("compare raised arithmetic flag");
    end
    assert_zero_flag_R7: assert (flagZero == (result == '0))
      else $error("zero flag mismatch");
    assert_neg_flag_R8: assert (flagNeg == result[MSB])
      else $error("negative flag mismatch");
  end

endmodule

bind alu_core alu_core_checker #(.WIDTH(WIDTH)) u_checker (
  .opA      (opA),
  .opB      (opB),
  .funcCode (funcCode),
  .carryIn  (carryIn),
  .result   (result),
  .flagZero (flagZero),
  .flagNeg  (flagNeg),
  .flagCarry(flagCarry),
  .flagOvf  (flagOvf)
);

// File: tb/alu_core_bench.sv
`timescale 1ns/1ps
module alu_core_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   funcCode = 3'd0;
  logic         carryIn = 1'b0;
  logic [W-1:0] result;
  logic         flagZero, flagNeg, flagCarry, flagOvf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu_core #(.WIDTH(W)) u_alu_core (
    .opA(opA), .opB(opB), .funcCode(funcCode), .carryIn(carryIn),
    .result(result), .flagZero(flagZero), .flagNeg(flagNeg),
    .flagCarry(flagCarry), .flagOvf(flagOvf)
  );

  // reference: {result, zero, neg, carry, ovf}
  function automatic logic [W+3:0] refModel(logic [W-1:0] a, logic [W-1:0] b,
                                            logic [2:0] fn, logic cin);
    logic [W-1:0] r;
    logic c, v;
    longint unsigned ua, ub, wide;
    ua = longint'(a); ub = longint'(b);
    c = 1'b0; v = 1'b0;
    case (fn)
      3'd0: begin
        wide = ua + ub + longint'(cin);
        r = wide[W-1:0]; c = wide[W];
        v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'd1: begin
        r = a - b; c = (ua >= ub);
        v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: r = ~(a | b);
      3'd6: r = ($signed(a) < $signed(b)) ? 1 : 0;
      default: r = (ua < ub) ? 1 : 0;
    endcase
    return {r, (r == '0), r[W-1], c, v};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2:0] fn, input logic cin, input string req);
    logic [W+3:0] exp, act;
    @(negedge clk);
    opA = a; opB = b; funcCode = fn; carryIn = cin;
    #2;
    exp = refModel(a, b, fn, cin);
    act = {result, flagZero, flagNeg, flagCarry, flagOvf};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s fn=%0d a=%h b=%h cin=%0b: actual res=%h z%0b n%0b c%0b v%0b expected res=%h z%0b n%0b c%0b v%0b",
               req, fn, a, b, cin, act[W+3:4], act[3], act[2], act[1], act[0],
               exp[W+3:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic test_reset_state();
    @(posedge rstN);
    apply('0, '0, 3'd0, 1'b0, "R7 reset-state zero");
  endtask

  task automatic test_add();  // R1 R3 R7
    apply(32'd5, 32'd7, 3'd0, 1'b0, "R1 add");
    apply(32'd5, 32'd7, 3'd0, 1'b1, "R1 add carry-in");
    apply(32'hFFFF_FFFF, 32'd1, 3'd0, 1'b0, "R1 R7 add wrap carry+zero");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd0, 1'b1, "R1 add all ones");
    apply(32'h7FFF_FFFF, 32'd1, 3'd0, 1'b0, "R3 add pos overflow");
    apply(32'h8000_0000, 32'h8000_0000, 3'd0, 1'b0, "R3 add neg overflow");
  endtask

  task automatic test_sub();  // R2 R3 R8
    apply(32'd9, 32'd4, 3'd1, 1'b0, "R2 sub no borrow");
    apply(32'd9, 32'd4, 3'd1, 1'b1, "R2 sub cin ignored");
    apply(32'd4, 32'd9, 3'd1, 1'b0, "R2 R8 sub borrow negative");
    apply(32'h1234_5678, 32'h1234_5678, 3'd1, 1'b1, "R2 R7 sub equal");
    apply(32'h8000_0000, 32'd1, 3'd1, 1'b0, "R3 sub overflow");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'd1, 1'b1, "R3 sub overflow pos");
  endtask

  task automatic test_logic();  // R4
    for (int fn = 2; fn <= 5; fn++) begin
      apply(32'hF0F0_A5A5, 32'hFF00_0F0F, 3'(fn), 1'b0, "R4 logic");
      apply(32'hF0F0_A5A5, 32'hFF00_0F0F, 3'(fn), 1'b1, "R4 logic cin ignored");
    end
    apply(32'd0, 32'd0, 3'd5, 1'b1, "R4 R8 nor all ones");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd4, 1'b0, "R4 R7 xor zero");
  endtask

  task automatic test_compare();  // R5 R6 R9
    apply(32'h8000_0000, 32'd1, 3'd6, 1'b0, "R5 slt overflowing subtract");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'd6, 1'b1, "R5 R9 slt overflow reverse");
    apply(32'hFFFF_FFFF, 32'd0, 3'd6, 1'b0, "R5 slt -1<0");
    apply(32'd3, 32'd3, 3'd6, 1'b0, "R5 slt equal");
    apply(32'hFFFF_FFFF, 32'd0, 3'd7, 1'b0, "R6 sltu big");
    apply(32'd0, 32'hFFFF_FFFF, 3'd7, 1'b1, "R6 R9 sltu small");
    apply(32'd7, 32'd7, 3'd7, 1'b0, "R6 sltu equal");
  endtask

  task automatic test_sweep();  // all requirements on pseudo-random data
    logic [W-1:0] s = 32'h1BAD_5EED;
    logic [W-1:0] t;
    for (int i = 0; i < 400; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      t = s;
      t ^= t << 13; t ^= t >> 17; t ^= t << 5;
      apply(s, (i % 5 == 0) ? s : t, 3'(i % 8), s[3], "R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");
    end
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        rstN = 1'b1;
      end
      begin
        test_reset_state();
        test_add();
        test_sub();
        test_logic();
        test_compare();
        test_sweep();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog: actual hung expected completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
          $finish;
        end
      end
    join_any
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule